// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block collects interrupt requests for a small 8-bit controller core and tells the instruction fetch unit which vector to load next. There are eight sources. Four are external pins. Each pin passes through a two-stage synchronizer, and a falling edge raises a request when that pin's enable bit is set. The other four are single-cycle event pulses from on-chip counters. Pins 2 and 3 share one flag bit, so the flag register is seven bits wide. The synchronized pin levels are always available as plain input data, whatever the enables hold.

Flags latch and stay set until software overwrites the flag register. Taking an interrupt does not clear them. A global enable is raised by an enable strobe or by the return-from-interrupt strobe, and lowered by a disable strobe. Hardware also lowers it when a hardware interrupt is accepted, so a second interrupt cannot nest. The fetch unit sees a one-cycle `vec_take` pulse, with `vec_addr` holding 0x000 after reset, 0x001 for a software interrupt, or 0x008 for a hardware interrupt.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted, `flag_q`, `gie` and `vec_take` are 0. On the first clock edge after reset release, `vec_take` pulses for one cycle with `vec_addr` = 0x000.
- R2: With its enable bit set, a falling edge on `ext_pin[i]` sets a flag bit. Pin 0 sets bit 0, pin 1 sets bit 1, and pins 2 and 3 both set bit 2. The bit becomes visible after the third rising clock edge that follows the pin change.
- R3: A pin whose enable bit (`pin_en_wdata[i]`, loaded when `pin_en_wr` is high, cleared by reset) is 0 sets no flag. A rising pin edge never sets a flag.
- R4: `pin_level` equals `ext_pin` delayed by two clock edges, whatever the enable bits hold.
- R5: A pulse on `cnt_evt[j]` sets flag bit 3+j at the next clock edge.
- R6: Flag bits stay set until `flag_wr` is high. A write loads `flag_wdata`, but a source event in the same cycle keeps its bit set.
- R7: `gie` rises after a cycle with `gie_set` or `reti` high and `gie_clr` low. `gie` falls after any cycle with `gie_clr` high.
- R8: When `gie` is 1, any flag is set, and no reset or software vector is due, the next edge pulses `vec_take` with `vec_addr` = 0x008 and clears `gie`. The flags stay as they are.
- R9: While `gie` is 0, set flags produce no hardware vector. The vector is taken once `gie` rises.
- R10: A `sw_irq` strobe gives `vec_take` with `vec_addr` = 0x001 at the next edge and leaves `gie` unchanged. It takes priority over a pending hardware vector, which follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | External interrupt pins (low four bits of the input port) |
| pin_en_wr | input | 1 | Load the pin enable register |
| pin_en_wdata | input | 4 | New pin enable bits |
| cnt_evt | input | CNT_N | Counter event pulses |
| flag_wr | input | 1 | Write strobe for the flag register |
| flag_wdata | input | 3+CNT_N | Flag write data |
| gie_set | input | 1 | Enable-interrupt instruction strobe |
| gie_clr | input | 1 | Disable-interrupt instruction strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| sw_irq | input | 1 | Software interrupt strobe |
| pin_level | output | 4 | Synchronized pin levels as general input data |
| flag_q | output | 3+CNT_N | Latched interrupt flags |
| gie | output | 1 | Global interrupt enable |
| vec_take | output | 1 | One-cycle request to load a vector |
| vec_addr | output | ADDR_W | Vector address to fetch |

## Verification
Directed sequences cover several cases, each aimed at one behaviour:
- A falling pin with its enable off against the same pin with it on, which separates the enable gating from the edge detector.
- Pins 2 and 3 falling together, which shows that their two requests merge into one flag bit.
- A flag write that lands in the same cycle as a counter event, which shows whether a clear can lose that event.
- Enable and disable strobes in the same cycle, which shows their priority.
- A software strobe arriving while a hardware vector is pending, which shows the vector priority and that `gie` survives a software vector.

Random pin toggles, enable writes, flag writes and strobes then mix all paths and are compared each cycle against a reference model.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int PIN_N       = 4;
  localparam int FLAG_PIN0   = 0;
  localparam int FLAG_PIN1   = 1;
  localparam int FLAG_PIN23  = 2;
  localparam int FLAG_CNT_LO = 3;
  localparam int SYNC_DEPTH  = 3;

  typedef enum logic [1:0] {
    VK_NONE,
    VK_RESET,
    VK_SOFT,
    VK_HARD
  } vec_kind_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] pin_i,
  output logic [PIN_N-1:0] level_o,
  output logic [PIN_N-1:0] fall_o
);
  for (genvar g = 0; g < PIN_N; g++) begin : g_pin
    logic [SYNC_DEPTH-1:0] sh_q;
    logic [SYNC_DEPTH-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[SYNC_DEPTH-2:0], pin_i[g]};
    end

    // idle-high pins: reset to ones so release makes no false edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= sh_d;
    end

    assign level_o[g] = sh_q[SYNC_DEPTH-2];
    assign fall_o[g]  = sh_q[SYNC_DEPTH-1] & ~sh_q[SYNC_DEPTH-2];
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_vec_pkg::*;
#(
  parameter int CNT_N = 4,
  localparam int FLAG_W = FLAG_CNT_LO + CNT_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_N-1:0]  fall_i,
  input  logic              en_wr_i,
  input  logic [PIN_N-1:0]  en_wdata_i,
  input  logic [CNT_N-1:0]  cnt_evt_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [FLAG_W-1:0] flag_o
);
  logic [PIN_N-1:0]  en_q, en_d;
  logic [PIN_N-1:0]  armed;
  logic [FLAG_W-1:0] set_v;
  logic [FLAG_W-1:0] flag_q, flag_d;

  always_comb begin
    armed = fall_i & en_q;
    set_v = '0;
    set_v[FLAG_PIN0]  = armed[0];
    set_v[FLAG_PIN1]  = armed[1];
    set_v[FLAG_PIN23] = armed[2] | armed[3];
    set_v[FLAG_CNT_LO +: CNT_N] = cnt_evt_i;
    // a new event wins over a software clear in the same cycle
    flag_d = wr_i ? (wdata_i | set_v) : (flag_q | set_v);
    en_d   = en_wr_i ? en_wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VEC_RESET = 'h000,
  parameter logic [ADDR_W-1:0] VEC_SOFT  = 'h001,
  parameter logic [ADDR_W-1:0] VEC_HARD  = 'h008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_any_i,
  input  logic              sw_irq_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              reti_i,
  output logic              gie_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              gie_q, gie_d;
  logic              rst_pend_q, rst_pend_d;
  logic              take_q, take_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  vec_kind_e         kind;

  always_comb begin
    kind = VK_NONE;
    if (rst_pend_q)              kind = VK_RESET;
    else if (sw_irq_i)           kind = VK_SOFT;
    else if (gie_q && flag_any_i) kind = VK_HARD;

    rst_pend_d = 1'b0;
    take_d     = (kind != VK_NONE);
    unique case (kind)
      VK_RESET: addr_d = VEC_RESET;
      VK_SOFT:  addr_d = VEC_SOFT;
      VK_HARD:  addr_d = VEC_HARD;
      default:  addr_d = addr_q;
    endcase

    if (kind == VK_HARD)         gie_d = 1'b0;
    else if (gie_clr_i)          gie_d = 1'b0;
    else if (gie_set_i || reti_i) gie_d = 1'b1;
    else                         gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q      <= 1'b0;
      rst_pend_q <= 1'b1;
      take_q     <= 1'b0;
      addr_q     <= VEC_RESET;
    end else begin
      gie_q      <= gie_d;
      rst_pend_q <= rst_pend_d;
      take_q     <= take_d;
      addr_q     <= addr_d;
    end
  end

  assign gie_o  = gie_q;
  assign take_o = take_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int CNT_N  = 4,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VEC_RESET = 'h000,
  parameter logic [ADDR_W-1:0] VEC_SOFT  = 'h001,
  parameter logic [ADDR_W-1:0] VEC_HARD  = 'h008,
  localparam int FLAG_W = FLAG_CNT_LO + CNT_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        ext_pin,
  input  logic              pin_en_wr,
  input  logic [3:0]        pin_en_wdata,
  input  logic [CNT_N-1:0]  cnt_evt,
  input  logic              flag_wr,
  input  logic [FLAG_W-1:0] flag_wdata,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              reti,
  input  logic              sw_irq,
  output logic [3:0]        pin_level,
  output logic [FLAG_W-1:0] flag_q,
  output logic              gie,
  output logic              vec_take,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [PIN_N-1:0] pin_fall;

  irq_pin_edge u_pin_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (ext_pin),
    .level_o (pin_level),
    .fall_o  (pin_fall)
  );

  irq_flag_bank #(.CNT_N(CNT_N)) u_flag_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (pin_fall),
    .en_wr_i    (pin_en_wr),
    .en_wdata_i (pin_en_wdata),
    .cnt_evt_i  (cnt_evt),
    .wr_i       (flag_wr),
    .wdata_i    (flag_wdata),
    .flag_o     (flag_q)
  );

  irq_vec_sel #(
    .ADDR_W    (ADDR_W),
    .VEC_RESET (VEC_RESET),
    .VEC_SOFT  (VEC_SOFT),
    .VEC_HARD  (VEC_HARD)
  ) u_vec_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_any_i (|flag_q),
    .sw_irq_i   (sw_irq),
    .gie_set_i  (gie_set),
    .gie_clr_i  (gie_clr),
    .reti_i     (reti),
    .gie_o      (gie),
    .take_o     (vec_take),
    .addr_o     (vec_addr)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int CNT_N  = 4,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VEC_RESET = 'h000,
  parameter logic [ADDR_W-1:0] VEC_SOFT  = 'h001,
  parameter logic [ADDR_W-1:0] VEC_HARD  = 'h008,
  localparam int FLAG_W = 3 + CNT_N
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag_wr,
  input logic              gie_set,
  input logic              gie_clr,
  input logic              reti,
  input logic              sw_irq,
  input logic [FLAG_W-1:0] flag_q,
  input logic              gie,
  input logic              vec_take,
  input logic [ADDR_W-1:0] vec_addr
);
  p_reset_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> (vec_take && vec_addr == VEC_RESET));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_gie_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((gie_set || reti) && !gie_clr && !gie) |=> gie);

  p_gie_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie);

  p_hw_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take && vec_addr == VEC_HARD) |-> (!gie && $past(gie) && ($past(flag_q) != '0)));

  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !sw_irq) |=> !(vec_take && vec_addr == VEC_HARD));

  p_soft_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_irq && $past(rst_n)) |=> (vec_take && vec_addr == VEC_SOFT));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .CNT_N(CNT_N), .ADDR_W(ADDR_W),
  .VEC_RESET(VEC_RESET), .VEC_SOFT(VEC_SOFT), .VEC_HARD(VEC_HARD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_wr(flag_wr), .gie_set(gie_set),
  .gie_clr(gie_clr), .reti(reti), .sw_irq(sw_irq), .flag_q(flag_q),
  .gie(gie), .vec_take(vec_take), .vec_addr(vec_addr)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_N  = 4;
  localparam int FLAG_W = 3 + CNT_N;
  localparam int ADDR_W = 12;
  localparam int WDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [3:0]        ext_pin;
  logic              pin_en_wr;
  logic [3:0]        pin_en_wdata;
  logic [CNT_N-1:0]  cnt_evt;
  logic              flag_wr;
  logic [FLAG_W-1:0] flag_wdata;
  logic              gie_set, gie_clr, reti, sw_irq;
  logic [3:0]        pin_level;
  logic [FLAG_W-1:0] flag_q;
  logic              gie, vec_take;
  logic [ADDR_W-1:0] vec_addr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference model state
  logic [3:0]        m_s1, m_s2, m_s3, m_en;
  logic [FLAG_W-1:0] m_flag;
  logic              m_gie, m_take, m_rp;
  logic [ADDR_W-1:0] m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pin_en_wr(pin_en_wr),
    .pin_en_wdata(pin_en_wdata), .cnt_evt(cnt_evt), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti(reti), .sw_irq(sw_irq), .pin_level(pin_level), .flag_q(flag_q),
    .gie(gie), .vec_take(vec_take), .vec_addr(vec_addr)
  );

  function automatic logic [FLAG_W-1:0] exp_events(input logic [3:0] fall,
      input logic [3:0] en, input logic [CNT_N-1:0] cev);
    logic [FLAG_W-1:0] s;
    logic [3:0] a;
    a = fall & en;
    s = '0;
    s[0] = a[0];
    s[1] = a[1];
    s[2] = a[2] | a[3];
    s[3 +: CNT_N] = cev;
    return s;
  endfunction

  task automatic model_reset();
    m_s1 = '1; m_s2 = '1; m_s3 = '1; m_en = '0;
    m_flag = '0; m_gie = 1'b0; m_take = 1'b0; m_rp = 1'b1; m_addr = '0;
  endtask

  task automatic model_step();
    logic [FLAG_W-1:0] ev;
    logic hw;
    ev = exp_events(m_s3 & ~m_s2, m_en, cnt_evt);
    hw = m_gie && (m_flag != '0);
    m_take = 1'b1;
    if (m_rp)         m_addr = 12'h000;
    else if (sw_irq)  m_addr = 12'h001;
    else if (hw)      m_addr = 12'h008;
    else              m_take = 1'b0;
    if (!m_rp && !sw_irq && hw)  m_gie = 1'b0;
    else if (gie_clr)            m_gie = 1'b0;
    else if (gie_set || reti)    m_gie = 1'b1;
    m_rp   = 1'b0;
    m_flag = flag_wr ? (flag_wdata | ev) : (m_flag | ev);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    if (pin_en_wr) m_en = pin_en_wdata;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
      input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "flag_q", 32'(flag_q), 32'(m_flag));
    chk(req, "gie", 32'(gie), 32'(m_gie));
    chk(req, "vec_take", 32'(vec_take), 32'(m_take));
    if (m_take) chk(req, "vec_addr", 32'(vec_addr), 32'(m_addr));
    chk(req, "pin_level", 32'(pin_level), 32'(m_s2));
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    compare(req);
  endtask

  task automatic quiet();
    pin_en_wr = 0; cnt_evt = '0; flag_wr = 0; flag_wdata = '0;
    gie_set = 0; gie_clr = 0; reti = 0; sw_irq = 0;
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(req);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 0; ext_pin = '1; pin_en_wdata = '0; quiet();
    model_reset();
    @(negedge clk);
    compare("R1");
    run(2, "R1");
    rst_n = 1;
    cyc("R1");            // reset vector pulse
    cyc("R1");            // pulse ends

    // R3: disabled pins set nothing; R4 levels still follow
    ext_pin = 4'b0000; run(4, "R3");
    ext_pin = 4'b1111; run(4, "R4");

    // R2: enable all pins, falling edges set flags, 2 and 3 share a bit
    pin_en_wr = 1; pin_en_wdata = 4'hF; cyc("R2"); quiet();
    ext_pin = 4'b1110; run(4, "R2");
    ext_pin = 4'b1111; run(4, "R3");  // rising edge sets nothing new
    ext_pin = 4'b0011; run(4, "R2");
    ext_pin = 4'b1111; run(3, "R2");

    // R5: counter events
    cnt_evt = 4'b0101; cyc("R5"); quiet(); run(2, "R5");

    // R6: clear with a same-cycle counter event that must survive
    flag_wr = 1; flag_wdata = '0; cnt_evt = 4'b0010; cyc("R6"); quiet();
    run(3, "R6");

    // R9: flags held, gie off, no vector
    run(4, "R9");

    // R7: set and clear together leaves gie low
    gie_set = 1; gie_clr = 1; cyc("R7"); quiet(); cyc("R7");
    // R8: enable, hardware vector follows and gie drops
    gie_set = 1; cyc("R8"); quiet(); run(3, "R8");
    flag_wr = 1; flag_wdata = '0; cyc("R6"); quiet();
    reti = 1; cyc("R7"); quiet(); run(2, "R7");

    // R10: software strobe while hardware vector is due
    cnt_evt = 4'b1000; sw_irq = 1; cyc("R10"); quiet();
    sw_irq = 1; cyc("R10"); quiet(); run(3, "R10");
    flag_wr = 1; flag_wdata = '0; cyc("R6"); quiet();
    gie_clr = 1; cyc("R7"); quiet(); cyc("R7");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      quiet();
      if ($urandom_range(0, 7) == 0) ext_pin = 4'($urandom);
      if ($urandom_range(0, 30) == 0) begin pin_en_wr = 1; pin_en_wdata = 4'($urandom); end
      if ($urandom_range(0, 15) == 0) cnt_evt = CNT_N'($urandom);
      if ($urandom_range(0, 10) == 0) begin flag_wr = 1; flag_wdata = FLAG_W'($urandom); end
      if ($urandom_range(0, 12) == 0) gie_set = 1;
      if ($urandom_range(0, 20) == 0) gie_clr = 1;
      if ($urandom_range(0, 20) == 0) reti = 1;
      if ($urandom_range(0, 30) == 0) sw_irq = 1;
      cyc("R8");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule